// File: doc/BRIEF.md
# Byte-Lane 16-bit SRAM Bridge

This block sits between a processor bus that issues both single-byte accesses and aligned 16-bit word accesses and a 16-bit-wide SRAM with separate upper and lower byte-lane enables. The CPU's byte address is split in two. The upper bits become the SRAM word address. Bit 0 never reaches the SRAM address pins and only chooses a byte lane. A byte written at any address is therefore stored in the same physical cell that a later aligned word fetch reads. If bit 0 were wired through to the memory address, bytes written at odd addresses would be invisible to word fetches.

Requests arrive on a valid/ready channel. A request moves when `req_valid` and `req_ready` are both high on a clock edge. The bridge drops `req_ready` while a read is in flight, and also while a read response is waiting and `rsp_ready` is low. Read responses leave on a second valid/ready channel. Once `rsp_valid` rises, `rsp_data` holds its value until a clock edge at which `rsp_ready` is high. Writes produce no response.

The SRAM is modelled as a single-cycle synchronous part. It acts on the command present at a clock edge, and read data is available from that edge onwards. The bridge registers every SRAM command pin.

Top module: `lane_sram_bridge`

## Requirements
- R1: For every accepted request, `sram_addr` equals `req_addr` shifted right by one bit, so CPU address bit 0 never appears on it.
- R2: For a byte access, exactly one lane enable is set: `sram_lane_en` is 2'b01 (lower lane, data bits 7:0) for an even address and 2'b10 (upper lane, bits 15:8) for an odd address.
- R3: For a word access, `sram_lane_en` is 2'b11, and `req_addr` bit 0 is ignored, so a word access at an odd address reaches the same word as the even address below it.
- R4: On a byte write, `sram_wdata` carries `req_wdata[7:0]` in both halves. On a word write, it carries `req_wdata` unchanged, with bits 7:0 going to the lower lane.
- R5: A byte read returns the enabled lane's byte on `rsp_data[7:0]`, with `rsp_data[15:8]` zero.
- R6: A word read returns the upper lane on `rsp_data[15:8]` and the lower lane on `rsp_data[7:0]`. A byte written at odd address A therefore appears in bits 15:8 of a later word read of A-1.
- R7: The SRAM command (`sram_cs` high, together with `sram_we`, address, lane enables and write data) appears one cycle after acceptance. `sram_cs` is high for exactly one cycle per accepted request. A read's `rsp_valid` is high in the second cycle after acceptance.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` stay unchanged and `req_ready` stays low.
- R9: During and right after reset, `sram_cs` and `rsp_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word access, 0 = byte access |
| req_addr | input | ADDR_W | CPU byte address |
| req_wdata | input | 16 | Write data; bits 7:0 for byte writes |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 16 | Read data |
| sram_cs | output | 1 | SRAM chip select, one cycle per access |
| sram_we | output | 1 | SRAM write enable |
| sram_lane_en | output | 2 | Lane enables: bit 1 upper, bit 0 lower |
| sram_addr | output | ADDR_W-1 | SRAM word address |
| sram_wdata | output | 16 | SRAM write data |
| sram_rdata | input | 16 | SRAM read data, valid after the read edge |

## Verification
The bench checks the results against a byte-array reference model. It first writes a distinct byte to every address of a small 64-byte memory. It then reads every word back, which separates a correct lane choice from address aliasing, because any use of bit 0 in the word address leaves odd bytes missing from word reads. It then reads every byte back, which shows whether the upper lane is shifted down correctly. Word writes through even and odd addresses, followed by byte reads, show that bit 0 is ignored for word accesses and that the halves are not swapped. A few read responses are held back with `rsp_ready` low, to test the hold rule and the blocking of `req_ready`.

// File: rtl/lane_bridge_pkg.sv
package lane_bridge_pkg;

  // Lane enable encodings on the SRAM side (bit 1 = upper, bit 0 = lower).
  localparam logic [1:0] LANE_LO   = 2'b01;
  localparam logic [1:0] LANE_HI   = 2'b10;
  localparam logic [1:0] LANE_BOTH = 2'b11;

  // Access kind carried alongside a read until its data returns.
  typedef struct packed {
    logic word;     // full 16-bit access
    logic hi_lane;  // byte access targets the upper lane
  } rd_tag_t;

endpackage

// File: rtl/lane_addr_map.sv
module lane_addr_map
  import lane_bridge_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic              is_word,
  output logic [ADDR_W-2:0] word_addr,
  output logic [1:0]        lane_en,
  output logic              hi_lane
);
  localparam int WADDR_W = ADDR_W - 1;

  // Bit 0 only selects a lane; it never contributes to the word address.
  assign word_addr = byte_addr[ADDR_W-1:1];
  assign hi_lane   = byte_addr[0] & ~is_word;

  always_comb begin
    if (is_word)       lane_en = LANE_BOTH;
    else if (hi_lane)  lane_en = LANE_HI;
    else               lane_en = LANE_LO;
  end

  always_comb begin
    // R2: a byte access never opens more than one lane
    assert_byte_single_lane_R2: assert (is_word || $countones(lane_en) == 1);
  end

  logic [WADDR_W-1:0] unused_w;
  assign unused_w = word_addr;
endmodule

// File: rtl/lane_wr_steer.sv
module lane_wr_steer #(
  parameter int LANE_W = 8
) (
  input  logic              is_word,
  input  logic [2*LANE_W-1:0] cpu_wdata,
  output logic [2*LANE_W-1:0] mem_wdata
);
  localparam int DATA_W = 2 * LANE_W;

  // A byte is copied onto every lane; whichever lane is enabled latches it.
  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_comb begin
      if (is_word) mem_wdata[g*LANE_W +: LANE_W] = cpu_wdata[g*LANE_W +: LANE_W];
      else         mem_wdata[g*LANE_W +: LANE_W] = cpu_wdata[LANE_W-1:0];
    end
  end

  logic [DATA_W-1:0] unused_d;
  assign unused_d = mem_wdata;
endmodule

// File: rtl/lane_rd_steer.sv
module lane_rd_steer #(
  parameter int LANE_W = 8
) (
  input  logic                is_word,
  input  logic                hi_lane,
  input  logic [2*LANE_W-1:0] mem_rdata,
  output logic [2*LANE_W-1:0] cpu_rdata
);
  always_comb begin
    if (is_word) begin
      cpu_rdata = mem_rdata;
    end else begin
      cpu_rdata = '0;
      cpu_rdata[LANE_W-1:0] = hi_lane ? mem_rdata[2*LANE_W-1:LANE_W]
                                      : mem_rdata[LANE_W-1:0];
    end
  end
endmodule

// File: rtl/lane_sram_bridge.sv
module lane_sram_bridge
  import lane_bridge_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic                req_word,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*LANE_W-1:0] req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [2*LANE_W-1:0] rsp_data,
  output logic                sram_cs,
  output logic                sram_we,
  output logic [1:0]          sram_lane_en,
  output logic [ADDR_W-2:0]   sram_addr,
  output logic [2*LANE_W-1:0] sram_wdata,
  input  logic [2*LANE_W-1:0] sram_rdata
);
  localparam int DATA_W  = 2 * LANE_W;
  localparam int WADDR_W = ADDR_W - 1;

  // ---------------- request decode ----------------
  logic               accept;
  logic [WADDR_W-1:0] map_addr;
  logic [1:0]         map_lanes;
  logic               map_hi;
  logic [DATA_W-1:0]  steer_wdata;

  lane_addr_map #(.ADDR_W(ADDR_W)) u_map (
    .byte_addr (req_addr),
    .is_word   (req_word),
    .word_addr (map_addr),
    .lane_en   (map_lanes),
    .hi_lane   (map_hi)
  );

  lane_wr_steer #(.LANE_W(LANE_W)) u_wr (
    .is_word   (req_word),
    .cpu_wdata (req_wdata),
    .mem_wdata (steer_wdata)
  );

  // ---------------- command stage (drives SRAM pins) ----------------
  logic               cs_q, we_q;
  logic [1:0]         lanes_q;
  logic [WADDR_W-1:0] addr_q;
  logic [DATA_W-1:0]  wdata_q;
  rd_tag_t            cmd_tag_q;

  // ---------------- return stage ----------------
  logic               pend_q;
  rd_tag_t            pend_tag_q;
  logic               rsp_valid_q;
  logic [DATA_W-1:0]  rsp_data_q;
  logic [DATA_W-1:0]  steer_rdata;
  logic               rd_cmd;

  assign rd_cmd    = cs_q & ~we_q;
  assign req_ready = ~(rd_cmd | pend_q | (rsp_valid_q & ~rsp_ready));
  assign accept    = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q      <= 1'b0;
      we_q      <= 1'b0;
      lanes_q   <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      cmd_tag_q <= '0;
    end else begin
      cs_q <= accept;
      if (accept) begin
        we_q      <= req_write;
        lanes_q   <= map_lanes;
        addr_q    <= map_addr;
        wdata_q   <= req_write ? steer_wdata : '0;
        cmd_tag_q <= '{word: req_word, hi_lane: map_hi};
      end
    end
  end

  assign sram_cs      = cs_q;
  assign sram_we      = we_q;
  assign sram_lane_en = lanes_q;
  assign sram_addr    = addr_q;
  assign sram_wdata   = wdata_q;

  // The SRAM acts on the command at the edge that ends the command cycle;
  // the tag travels one stage further so it lines up with sram_rdata.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_tag_q <= '0;
    end else begin
      pend_q     <= rd_cmd;
      pend_tag_q <= cmd_tag_q;
    end
  end

  lane_rd_steer #(.LANE_W(LANE_W)) u_rd (
    .is_word   (pend_tag_q.word),
    .hi_lane   (pend_tag_q.hi_lane),
    .mem_rdata (sram_rdata),
    .cpu_rdata (steer_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (pend_q) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= steer_rdata;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  // ---------------- assertions ----------------
  // R1: word address is the byte address without bit 0
  assert_addr_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> sram_addr == $past(req_addr[ADDR_W-1:1]));

  // R2: byte access opens only the lane chosen by bit 0
  assert_byte_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_word) |=>
      (sram_lane_en == ($past(req_addr[0]) ? LANE_HI : LANE_LO)));

  // R3: word access opens both lanes
  assert_word_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_word) |=> sram_lane_en == LANE_BOTH);

  // R4: byte write data appears in both halves
  assert_wr_replicate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && !req_word) |=>
      (sram_wdata[DATA_W-1:LANE_W] == sram_wdata[LANE_W-1:0]));

  // R7: chip select follows acceptance by one cycle, one pulse each
  assert_cs_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !sram_cs);

  // R8: a held response does not change
  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R8: returning data never overwrites an untaken response
  assert_no_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (!rsp_valid || rsp_ready));

endmodule

// File: tb/lane_sram_bridge_bench.sv
module lane_sram_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int NBYTE = 1 << AW;
  localparam int NWORD = NBYTE / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic rsp_ready = 1'b1;
  logic req_ready, rsp_valid, sram_cs, sram_we;
  logic [15:0] rsp_data, sram_wdata;
  logic [15:0] sram_rdata = '0;
  logic [1:0] sram_lane_en;
  logic [AW-2:0] sram_addr;

  int checks = 0;
  int fails  = 0;

  logic [15:0] sram_mem [NWORD];
  logic [7:0]  ref_mem  [NBYTE];

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_sram_bridge #(.ADDR_W(AW), .LANE_W(8)) u_lane_sram_bridge (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_word, .req_addr,
    .req_wdata, .rsp_valid, .rsp_ready, .rsp_data, .sram_cs, .sram_we,
    .sram_lane_en, .sram_addr, .sram_wdata, .sram_rdata
  );

  // Single-cycle synchronous SRAM with per-lane write enables.
  always @(posedge clk) begin
    if (sram_cs) begin
      if (sram_we) begin
        if (sram_lane_en[0]) sram_mem[sram_addr][7:0]  <= sram_wdata[7:0];
        if (sram_lane_en[1]) sram_mem[sram_addr][15:8] <= sram_wdata[15:8];
      end else begin
        sram_rdata <= sram_mem[sram_addr];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One request; checks pins and timing; returns read data.
  task automatic issue(input bit wr, input bit wd, input logic [AW-1:0] a,
                       input logic [15:0] d, input bit stall,
                       output logic [15:0] got);
    logic [1:0]  exp_lanes;
    logic [15:0] held;
    got = '0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = d;
    rsp_ready = !stall;
    @(negedge clk);
    req_valid = 1'b0;
    exp_lanes = wd ? 2'b11 : (a[0] ? 2'b10 : 2'b01);
    chk(sram_cs === 1'b1, "R7", "cs after accept", 32'(sram_cs), 1);
    chk(sram_we === wr, "R7", "we", 32'(sram_we), 32'(wr));
    chk(sram_addr === a[AW-1:1], "R1", "word address", 32'(sram_addr), 32'(a[AW-1:1]));
    chk(sram_lane_en === exp_lanes, wd ? "R3" : "R2", "lane enables",
        32'(sram_lane_en), 32'(exp_lanes));
    if (wr) begin
      logic [15:0] ew;
      ew = wd ? d : {d[7:0], d[7:0]};
      chk(sram_wdata === ew, "R4", "write data", 32'(sram_wdata), 32'(ew));
    end
    @(negedge clk);
    chk(sram_cs === 1'b0, "R7", "cs single pulse", 32'(sram_cs), 0);
    if (!wr) begin
      chk(req_ready === 1'b0, "R8", "ready low with read in flight", 32'(req_ready), 0);
      @(negedge clk);
      chk(rsp_valid === 1'b1, "R7", "rsp_valid two cycles after accept", 32'(rsp_valid), 1);
      got = rsp_data;
      if (stall) begin
        held = rsp_data;
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk(rsp_valid === 1'b1, "R8", "valid held", 32'(rsp_valid), 1);
          chk(rsp_data === held, "R8", "data held", 32'(rsp_data), 32'(held));
          chk(req_ready === 1'b0, "R8", "ready low while stalled", 32'(req_ready), 0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R8", "valid drops after take", 32'(rsp_valid), 0);
        chk(req_ready === 1'b1, "R8", "ready back", 32'(req_ready), 1);
      end
    end
  endtask

  task automatic ref_write(input bit wd, input logic [AW-1:0] a, input logic [15:0] d);
    if (wd) begin
      ref_mem[{a[AW-1:1], 1'b0}] = d[7:0];
      ref_mem[{a[AW-1:1], 1'b1}] = d[15:8];
    end else begin
      ref_mem[a] = d[7:0];
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [15:0] got, exp;
    for (int i = 0; i < NWORD; i++) sram_mem[i] = '0;
    for (int i = 0; i < NBYTE; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(sram_cs === 1'b0, "R9", "cs in reset", 32'(sram_cs), 0);
    chk(rsp_valid === 1'b0, "R9", "rsp_valid in reset", 32'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R9", "ready after reset", 32'(req_ready), 1);
    chk(sram_cs === 1'b0, "R9", "cs after reset", 32'(sram_cs), 0);

    // Byte writes at every address, even and odd.
    for (int a = 0; a < NBYTE; a++) begin
      logic [15:0] d;
      d = {8'hA5, 8'(a * 37 + 5)};
      issue(1'b1, 1'b0, AW'(a), d, 1'b0, got);
      ref_write(1'b0, AW'(a), d);
    end

    // R6: every aligned word read sees both bytes written earlier.
    for (int w = 0; w < NWORD; w++) begin
      issue(1'b0, 1'b1, AW'(2 * w), 16'h0, (w % 8) == 5, got);
      exp = {ref_mem[2 * w + 1], ref_mem[2 * w]};
      chk(got === exp, "R6", "word read after byte writes", 32'(got), 32'(exp));
    end

    // R5: byte reads return the lane on bits 7:0, upper zero.
    for (int a = 0; a < NBYTE; a++) begin
      issue(1'b0, 1'b0, AW'(a), 16'h0, (a % 16) == 3, got);
      exp = {8'h00, ref_mem[a]};
      chk(got === exp, "R5", "byte read", 32'(got), 32'(exp));
    end

    // R3/R4: word writes, half through odd addresses.
    for (int w = 0; w < NWORD; w += 3) begin
      logic [AW-1:0] a;
      logic [15:0] d;
      a = AW'(2 * w + (w % 2));
      d = 16'(w * 1031 + 16'h3C11);
      issue(1'b1, 1'b1, a, d, 1'b0, got);
      ref_write(1'b1, a, d);
    end
    for (int a = 0; a < NBYTE; a++) begin
      issue(1'b0, 1'b0, AW'(a), 16'h0, 1'b0, got);
      exp = {8'h00, ref_mem[a]};
      chk(got === exp, "R4", "byte read after word write", 32'(got), 32'(exp));
    end

    // R3: word read via odd address equals word at even address.
    for (int w = 0; w < NWORD; w += 5) begin
      issue(1'b0, 1'b1, AW'(2 * w + 1), 16'h0, 1'b0, got);
      exp = {ref_mem[2 * w + 1], ref_mem[2 * w]};
      chk(got === exp, "R3", "word read at odd address", 32'(got), 32'(exp));
    end

    // R6: overwrite odd bytes only, then word fetch.
    for (int w = 0; w < NWORD; w += 4) begin
      logic [15:0] d;
      d = {8'h00, 8'(8'hC3 ^ w)};
      issue(1'b1, 1'b0, AW'(2 * w + 1), d, 1'b0, got);
      ref_write(1'b0, AW'(2 * w + 1), d);
      issue(1'b0, 1'b1, AW'(2 * w), 16'h0, 1'b0, got);
      exp = {ref_mem[2 * w + 1], ref_mem[2 * w]};
      chk(got === exp, "R6", "odd byte visible in upper half", 32'(got), 32'(exp));
    end

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule